// File: doc/BRIEF.md
# Three-Wire Serial Configuration Word Store

This block is a synthesizable model of a small serial configuration memory of 64 words by 16 bits, driven over a three-wire link made of a select line, a serial clock and a serial data input, with one serial data output. A host raises select and then clocks in a command. The command is a leading 1, a two-bit operation code and a 6-bit word address, each bit taken on a rising edge of the serial clock. Depending on the code, the block then sends a stored word back or takes in 16 more bits. Dropping select ends the exchange at any point.

The model runs from a fast system clock and detects serial clock rising edges itself. The word array sits in ordinary registers. A single enable latch guards every operation that changes the array. The latch is cleared by reset and is set or cleared by two special commands. Programming delays, analog timing limits and retention are not modelled.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the data output is 1, modifying commands are disabled and every word reads back as FFFFh.
- R2: While select is high and no command is in progress, 0 bits on the data input are ignored; a command begins only at the first 1 bit.
- R3: On the serial clock rise that carries the sixth and last address bit, the data output goes to 0 and stays there until the next serial clock rise.
- R4: Code 10 returns the addressed word on the 16 serial clock rises after the address, most significant bit first, one bit on each rise.
- R5: Code 01 takes the 16 bits that follow the address, most significant bit first, and stores them at the address when modifying commands are enabled.
- R6: Code 11 sets the addressed word to FFFFh when modifying commands are enabled.
- R7: Code 00 decodes the two most significant address bits as a sub-command: 11 enables modifying commands and 00 disables them.
- R8: Code 00 with sub-command 10 sets every word to FFFFh when modifying commands are enabled.
- R9: Code 00 with sub-command 01 takes 16 data bits and stores them in every word when modifying commands are enabled.
- R10: While modifying commands are disabled, the write, erase, erase-all and write-all commands leave the array unchanged.
- R11: Dropping select abandons the current command without storing anything, holds the data output at 1 while select is low, and makes the next command wait for a new leading 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| csIn | input | 1 | Select; high frames a command |
| skIn | input | 1 | Serial clock; bits are taken on its rising edge |
| diIn | input | 1 | Serial data into the block |
| doOut | output | 1 | Serial data out; 1 when idle, 0 as the address-end marker, then read bits |

## Verification
The bench first writes a distinct value to every one of the 64 words and reads them all back, so that a swapped or shifted address bit, or a read word that comes out in the wrong bit order, shows up as a wrong value at some address. Each read also checks the address-end zero, which a parser counting one address bit too few or too many would put in the wrong place. Every array-changing command is replayed while disabled, and a broken enable latch would leave altered words behind. A write cut short by dropping select, and commands preceded by stray zeros, catch a parser that commits partial data or stays out of step with the next command.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_DISABLE  = 2'b00;
  localparam logic [1:0] SUB_WRALL    = 2'b01;
  localparam logic [1:0] SUB_ERALL    = 2'b10;
  localparam logic [1:0] SUB_ENABLE   = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RDATA, ST_WDATA, ST_DONE
  } mwState_t;

  typedef struct packed {
    logic shiftOp;
    logic shiftAddr;
    logic lastAddr;
    logic shiftOut;
    logic shiftData;
    logic lastData;
    logic idleOut;
  } mwStrb_t;

endpackage

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csIn,
  input  logic       skIn,
  input  logic       diIn,
  input  logic [1:0] opCode,
  input  logic [1:0] addrHi,
  output mwStrb_t    strb
);

  localparam int CNT_W = $clog2(DATA_W > ADDR_W ? DATA_W : ADDR_W) + 1;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  mwState_t state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic skPrev;
  logic skRise;

  assign skRise = skIn & ~skPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      skPrev <= 1'b0;
    end else begin
      state  <= stateNxt;
      cnt    <= cntNxt;
      skPrev <= skIn;
    end
  end

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    strb     = '0;
    if (!csIn) begin
      stateNxt     = ST_IDLE;
      cntNxt       = '0;
      strb.idleOut = 1'b1;
    end else if (skRise) begin
      unique case (state)
        ST_IDLE: begin
          if (diIn) begin
            stateNxt = ST_OPC;
            cntNxt   = '0;
          end
        end
        ST_OPC: begin
          strb.shiftOp = 1'b1;
          if (cnt == CNT_W'(1)) begin
            stateNxt = ST_ADDR;
            cntNxt   = '0;
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
        ST_ADDR: begin
          strb.shiftAddr = 1'b1;
          if (cnt == ADDR_LAST) begin
            strb.lastAddr = 1'b1;
            cntNxt        = '0;
            unique case (opCode)
              OP_READ:  stateNxt = ST_RDATA;
              OP_WRITE: stateNxt = ST_WDATA;
              OP_EXT:   stateNxt = (addrHi == SUB_WRALL) ? ST_WDATA : ST_DONE;
              default:  stateNxt = ST_DONE;
            endcase
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
        ST_RDATA: begin
          strb.shiftOut = 1'b1;
          if (cnt == DATA_LAST) stateNxt = ST_DONE;
          else cntNxt = cnt + 1'b1;
        end
        ST_WDATA: begin
          strb.shiftData = 1'b1;
          strb.idleOut   = 1'b1;
          if (cnt == DATA_LAST) begin
            strb.lastData = 1'b1;
            stateNxt      = ST_DONE;
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
        default: begin
          strb.idleOut = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/mw_eeprom_dp.sv
module mw_eeprom_dp
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       diIn,
  input  mwStrb_t    strb,
  output logic [1:0] opCode,
  output logic [1:0] addrHi,
  output logic       wrEnable,
  output logic       doOut
);

  localparam int WORDS = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] ERASED = '1;

  logic [1:0]        opReg;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] addrNext;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] outReg;
  logic [DATA_W-1:0] wordNext;
  logic [DATA_W-1:0] memArr [WORDS];

  assign addrNext = {addrReg[ADDR_W-2:0], diIn};
  assign wordNext = {dataReg[DATA_W-2:0], diIn};
  assign opCode   = opReg;
  assign addrHi   = addrReg[ADDR_W-2 -: 2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg    <= '0;
      addrReg  <= '0;
      dataReg  <= '0;
      outReg   <= '0;
      doOut    <= 1'b1;
      wrEnable <= 1'b0;
      for (int i = 0; i < WORDS; i++) memArr[i] <= ERASED;
    end else begin
      if (strb.shiftOp)   opReg   <= {opReg[0], diIn};
      if (strb.shiftAddr) addrReg <= addrNext;
      if (strb.shiftData) dataReg <= wordNext;
      if (strb.idleOut)   doOut   <= 1'b1;
      if (strb.shiftOut) begin
        doOut  <= outReg[DATA_W-1];
        outReg <= {outReg[DATA_W-2:0], 1'b0};
      end
      if (strb.lastAddr) begin
        doOut <= 1'b0;
        unique case (opReg)
          OP_READ:  outReg <= memArr[addrNext];
          OP_ERASE: if (wrEnable) memArr[addrNext] <= ERASED;
          OP_EXT: begin
            unique case (addrNext[ADDR_W-1 -: 2])
              SUB_ENABLE:  wrEnable <= 1'b1;
              SUB_DISABLE: wrEnable <= 1'b0;
              SUB_ERALL: begin
                if (wrEnable)
                  for (int i = 0; i < WORDS; i++) memArr[i] <= ERASED;
              end
              default: ;
            endcase
          end
          default: ;
        endcase
      end
      if (strb.lastData && wrEnable) begin
        if (opReg == OP_WRITE) begin
          memArr[addrReg] <= wordNext;
        end else begin
          for (int i = 0; i < WORDS; i++) memArr[i] <= wordNext;
        end
      end
    end
  end

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  output logic doOut
);

  mwStrb_t    ctrlStrb;
  logic [1:0] opCode;
  logic [1:0] addrHi;
  logic       wrEnable;

  mw_eeprom_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csIn   (csIn),
    .skIn   (skIn),
    .diIn   (diIn),
    .opCode (opCode),
    .addrHi (addrHi),
    .strb   (ctrlStrb)
  );

  mw_eeprom_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .diIn     (diIn),
    .strb     (ctrlStrb),
    .opCode   (opCode),
    .addrHi   (addrHi),
    .wrEnable (wrEnable),
    .doOut    (doOut)
  );

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mw_eeprom_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    csIn,
  input logic    doOut,
  input mwStrb_t strb,
  input logic    wrEnable
);

  // Output parked high one cycle after select is low (R11)
  assert_idle_high_R11: assert property (@(posedge clk) disable iff (!rstN)
    !csIn |=> doOut);

  // Address-end marker appears right after the last address bit (R3)
  assert_dummy_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.lastAddr |=> !doOut);

  // No bit is consumed while select is low (R2)
  assert_no_shift_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !csIn |-> !(strb.shiftOp | strb.shiftAddr | strb.shiftData | strb.shiftOut));

  // One serial phase at a time (R4)
  assert_single_phase_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftOp, strb.shiftAddr, strb.shiftData, strb.shiftOut}));

  // Enable latch only moves on a completed address field (R7)
  assert_enable_move_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnable != $past(wrEnable)) |-> $past(strb.lastAddr));

  // Stored data only committed with select high (R11)
  assert_commit_selected_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.lastData |-> csIn);

endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .csIn     (csIn),
  .doOut    (doOut),
  .strb     (ctrlStrb),
  .wrEnable (wrEnable)
);

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csIn = 1'b0;
  logic skIn = 1'b0;
  logic diIn = 1'b0;
  logic doOut;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [WORDS];
  logic enModel = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mw_eeprom dut (
    .clk   (clk),
    .rstN  (rstN),
    .csIn  (csIn),
    .skIn  (skIn),
    .diIn  (diIn),
    .doOut (doOut)
  );

  function automatic logic [15:0] pat(int a);
    return 16'((a * 1841) ^ 16'hA5C3);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, output logic sampled);
    diIn = b;
    skIn = 1'b1;
    repeat (3) @(negedge clk);
    sampled = doOut;
    skIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic runCmd(input logic [1:0] op, input logic [5:0] addr, input logic [15:0] wdata,
                        input int lead, output logic [15:0] rd, output logic marker);
    logic t;
    rd = '0;
    marker = 1'b1;
    csIn = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < lead; i++) sendBit(1'b0, t);
    sendBit(1'b1, t);
    for (int i = 1; i >= 0; i--) sendBit(op[i], t);
    for (int i = 5; i >= 0; i--) begin
      sendBit(addr[i], t);
      if (i == 0) marker = t;
    end
    if (op == 2'b10) begin
      for (int i = 15; i >= 0; i--) begin
        sendBit(1'b0, t);
        rd = {rd[14:0], t};
      end
    end else if (op == 2'b01 || (op == 2'b00 && addr[5:4] == 2'b01)) begin
      for (int i = 15; i >= 0; i--) sendBit(wdata[i], t);
    end
    csIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic readCheck(input int a, input string req, input int lead);
    logic [15:0] rd;
    logic mk;
    runCmd(2'b10, 6'(a), 16'h0, lead, rd, mk);
    check("R3 marker", {15'h0, mk}, 16'h0);
    check(req, rd, model[a]);
  endtask

  task automatic readAll(input string req);
    for (int a = 0; a < WORDS; a++) readCheck(a, req, 0);
  endtask

  task automatic simpleCmd(input logic [1:0] op, input logic [5:0] addr, input logic [15:0] wd);
    logic [15:0] rd;
    logic mk;
    runCmd(op, addr, wd, 0, rd, mk);
    if (op == 2'b00 && addr[5:4] == 2'b11) enModel = 1'b1;
    else if (op == 2'b00 && addr[5:4] == 2'b00) enModel = 1'b0;
    else if (enModel) begin
      if (op == 2'b01) model[addr] = wd;
      else if (op == 2'b11) model[addr] = 16'hFFFF;
      else if (op == 2'b00 && addr[5:4] == 2'b10)
        for (int a = 0; a < WORDS; a++) model[a] = 16'hFFFF;
      else if (op == 2'b00 && addr[5:4] == 2'b01)
        for (int a = 0; a < WORDS; a++) model[a] = wd;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic t;
    for (int a = 0; a < WORDS; a++) model[a] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: idle output and erased array after reset
    check("R1 doOut", {15'h0, doOut}, 16'h1);
    readCheck(0, "R1 erased", 0);
    readCheck(63, "R1 erased", 0);

    // R10: writes refused while disabled out of reset
    simpleCmd(2'b01, 6'd5, 16'h1234);
    readCheck(5, "R10 write refused", 0);

    // R7: enable
    simpleCmd(2'b00, 6'b110000, 16'h0);

    // R5 / R4: distinct word everywhere, read back
    for (int a = 0; a < WORDS; a++) simpleCmd(2'b01, 6'(a), pat(a));
    readAll("R4 R5 read back");

    // R2: stray zeros ahead of the start bit
    readCheck(17, "R2 leading zeros", 3);
    readCheck(42, "R2 leading zeros", 1);

    // R6: erase a subset
    for (int a = 0; a < WORDS; a += 7) simpleCmd(2'b11, 6'(a), 16'h0);
    readAll("R6 erase");

    // R11: write cut short by select drop
    csIn = 1'b1;
    repeat (2) @(negedge clk);
    sendBit(1'b1, t);
    sendBit(1'b0, t);
    sendBit(1'b1, t);
    for (int i = 5; i >= 0; i--) sendBit(((6'd9 >> i) & 6'd1) != 0, t);
    for (int i = 0; i < 8; i++) sendBit(i[0], t);
    csIn = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 idle high", {15'h0, doOut}, 16'h1);
    repeat (2) @(negedge clk);
    readCheck(9, "R11 abort no store", 0);
    readCheck(10, "R11 next command", 0);

    // R7 / R10: disable, then every modifying command refused
    simpleCmd(2'b00, 6'b000000, 16'h0);
    simpleCmd(2'b11, 6'd1, 16'h0);
    simpleCmd(2'b01, 6'd2, 16'hBEEF);
    simpleCmd(2'b00, 6'b100000, 16'h0);
    simpleCmd(2'b00, 6'b010000, 16'h0F0F);
    readAll("R10 R7 protected");

    // R9: write all
    simpleCmd(2'b00, 6'b110000, 16'h0);
    simpleCmd(2'b00, 6'b010101, 16'h5A3C);
    readAll("R9 write all");

    // R8: erase all
    simpleCmd(2'b00, 6'b101010, 16'h0);
    readAll("R8 erase all");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule